// File: doc/BRIEF.md
# Bridge Command Register and Upstream Request Gate

This block holds the command register of one virtual PCI-to-PCI bridge port and applies it to the traffic and events that pass through the port. Configuration software writes and reads the register through a simple write strobe and a continuous read bus. Five bits are writable:

- error-message enable
- parity-response enable
- bus-master enable
- memory-window enable
- I/O-window enable

Every other bit reads as zero.

Upstream requests carry a valid/ready handshake and four attributes: direction (read or write), space (memory or I/O), address and byte enables. An MSI, a peer access or an ordinary access all arrive as plain memory or I/O requests. When bus mastering is enabled, a request passes through unchanged in the same cycle. When it is disabled, the request is not dropped. It is redirected to a fixed legacy memory address instead:

- a redirected write loses all its byte enables;
- a redirected read is flagged so that its completion returns Unsupported Request.

Completions travelling toward the secondary side pass straight through, whatever the command register holds.

The two window-enable bits drive the enables of the address decoders. The first of them drives both the memory decoder and the prefetchable memory decoder. The parity-response bit decides whether a detected master data parity error can set a sticky status bit, which software clears by writing 1. A primary-side error event produces a one-cycle message strobe when either the local enable or the device-control reporting enable is set.

Top module: `bridge_cmd_gate`

## Requirements
- R1: After reset, the command register reads 0x0000, all three window enables are 0, the parity status bit is 0 and no message strobe is produced.
- R2: A configuration write stores bits 8 (error-message enable), 6 (parity-response enable), 2 (bus-master enable), 1 (memory-window enable) and 0 (I/O-window enable); every other bit of the 16-bit read value is 0, whatever was written.
- R3: With bit 2 set, a request leaves with the same direction, space, address and byte enables it arrived with, in the same cycle, and its unsupported flag is 0.
- R4: With bit 2 clear, a write request (memory or I/O, including an MSI) leaves as a memory write to the redirect address (default 0xC0000, zero-extended to the address width), with all byte enables 0 and the unsupported flag 0.
- R5: With bit 2 clear, a read request (memory or I/O) leaves as a memory read to the redirect address with its byte enables unchanged and the unsupported flag set to 1.
- R6: The completion valid and payload pass from input to output unchanged and in the same cycle, for either value of bit 2.
- R7: Bit 1 drives both the memory and prefetchable window enables; bit 0 drives the I/O window enable.
- R8: A detected parity error sets the status bit only while bit 6 is 1. A clear strobe (write-1-to-clear) resets the status bit. If a set and a clear arrive in the same cycle, the set wins.
- R9: Each cycle in which the primary error input is high gives exactly one one-cycle message strobe in the following cycle, if bit 8 or the device-control reporting input is 1; otherwise it gives no strobe.
- R10: The request output valid equals the input valid and the input ready equals the output ready, for either value of bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Command register write strobe |
| cfg_wr_data | input | 16 | Command register write value |
| cfg_rd_data | output | 16 | Command register read value |
| dev_err_report_en | input | 1 | Error reporting enable from device control |
| up_valid | input | 1 | Upstream request valid |
| up_ready | output | 1 | Upstream request ready |
| up_write | input | 1 | Request is a write (1) or read (0) |
| up_io | input | 1 | Request targets I/O (1) or memory (0) space |
| up_addr | input | ADDR_W | Request address |
| up_be | input | BE_W | Request byte enables |
| dn_valid | output | 1 | Gated request valid |
| dn_ready | input | 1 | Gated request ready |
| dn_write | output | 1 | Gated request direction |
| dn_io | output | 1 | Gated request space |
| dn_addr | output | ADDR_W | Gated request address |
| dn_be | output | BE_W | Gated request byte enables |
| dn_ur | output | 1 | Read blocked, completes as Unsupported Request |
| cpl_in_valid | input | 1 | Completion from primary side valid |
| cpl_in_data | input | CPL_W | Completion payload |
| cpl_out_valid | output | 1 | Completion to secondary side valid |
| cpl_out_data | output | CPL_W | Completion payload out |
| mem_win_en | output | 1 | Memory window decode enable |
| pref_win_en | output | 1 | Prefetchable memory window decode enable |
| io_win_en | output | 1 | I/O window decode enable |
| err_primary | input | 1 | Primary-side error event (one per high cycle) |
| perr_detect | input | 1 | Master data parity error detected |
| perr_clr | input | 1 | Write-1-to-clear strobe for the parity status bit |
| serr_msg | output | 1 | Error message strobe |
| perr_status | output | 1 | Master data parity error status |

## Verification
The bench builds the block with a 40-bit address, 8 byte enables and a 24-bit completion payload. With these widths the upper address bits above the 20-bit legacy address come into reach. This shows that a redirect clears them as well as replacing the low bits, and that a full byte-enable mask is zeroed. The default redirect address is kept, so the fixed 0xC0000 target is compared directly. Requests are sent with all four direction and space combinations under both values of the bus-master bit, including sends held under back-pressure.

// File: rtl/bridge_cmd_gate.sv
module bridge_cmd_gate #(
  parameter int ADDR_W = 32,
  parameter int BE_W   = 4,
  parameter int CPL_W  = 32,
  parameter logic [ADDR_W-1:0] REDIRECT_ADDR = ADDR_W'(20'hC0000)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [15:0]       cfg_wr_data,
  output logic [15:0]       cfg_rd_data,
  input  logic              dev_err_report_en,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic              up_write,
  input  logic              up_io,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [BE_W-1:0]   up_be,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic              dn_write,
  output logic              dn_io,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [BE_W-1:0]   dn_be,
  output logic              dn_ur,
  input  logic              cpl_in_valid,
  input  logic [CPL_W-1:0]  cpl_in_data,
  output logic              cpl_out_valid,
  output logic [CPL_W-1:0]  cpl_out_data,
  output logic              mem_win_en,
  output logic              pref_win_en,
  output logic              io_win_en,
  input  logic              err_primary,
  input  logic              perr_detect,
  input  logic              perr_clr,
  output logic              serr_msg,
  output logic              perr_status
);

  localparam int B_SERR = 8;
  localparam int B_PERR = 6;
  localparam int B_BME  = 2;
  localparam int B_MEM  = 1;
  localparam int B_IO   = 0;
  localparam logic [15:0] RW_MASK = 16'((1 << B_SERR) | (1 << B_PERR) |
                                        (1 << B_BME) | (1 << B_MEM) | (1 << B_IO));

  logic [15:0] cmd_q;
  logic        bme, perre, serre;

  always_ff @(posedge clk) begin
    if (!rst_n) cmd_q <= '0;
    else if (cfg_wr_en) cmd_q <= cfg_wr_data & RW_MASK;
  end

  assign cfg_rd_data = cmd_q;
  assign bme   = cmd_q[B_BME];
  assign perre = cmd_q[B_PERR];
  assign serre = cmd_q[B_SERR];

  assign mem_win_en  = cmd_q[B_MEM];
  assign pref_win_en = cmd_q[B_MEM];
  assign io_win_en   = cmd_q[B_IO];

  // Upstream gate: closed gate redirects rather than drops
  assign dn_valid = up_valid;
  assign up_ready = dn_ready;
  assign dn_write = up_write;
  assign dn_io    = bme & up_io;
  assign dn_addr  = bme ? up_addr : REDIRECT_ADDR;
  assign dn_be    = (bme || !up_write) ? up_be : '0;
  assign dn_ur    = !bme && !up_write;

  assign cpl_out_valid = cpl_in_valid;
  assign cpl_out_data  = cpl_in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      serr_msg    <= 1'b0;
      perr_status <= 1'b0;
    end else begin
      serr_msg <= err_primary && (serre || dev_err_report_en);
      if (perr_detect && perre) perr_status <= 1'b1;
      else if (perr_clr)        perr_status <= 1'b0;
    end
  end

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_data & ~RW_MASK) == 16'h0);

  a_r4_write_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !cfg_rd_data[B_BME] && up_write) |->
      (dn_addr == REDIRECT_ADDR && dn_be == '0 && !dn_io && !dn_ur));

  a_r5_read_unsupported: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !cfg_rd_data[B_BME] && !up_write) |-> (dn_ur && dn_be == up_be));

  a_r3_open_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && cfg_rd_data[B_BME]) |-> (dn_addr == up_addr && !dn_ur));

  a_r8_perr_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(perr_status) |-> ($past(perre) && $past(perr_detect)));

  a_r9_serr_cause: assert property (@(posedge clk) disable iff (!rst_n)
    serr_msg |-> $past(err_primary));

  a_r10_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    (up_ready == dn_ready) && (dn_valid == up_valid));

endmodule

// File: tb/sim_bridge_cmd_gate.sv
`timescale 1ns/1ps
module sim_bridge_cmd_gate;
  localparam int AW = 40;
  localparam int BW = 8;
  localparam int CW = 24;
  localparam logic [AW-1:0] RDIR = AW'(20'hC0000);

  typedef struct packed {
    logic          wr;
    logic          io;
    logic [AW-1:0] addr;
    logic [BW-1:0] be;
    logic          ur;
  } req_t;

  logic clk = 0, rst_n = 0;
  logic cfg_wr_en = 0; logic [15:0] cfg_wr_data = 0; logic [15:0] cfg_rd_data;
  logic dev_err_report_en = 0;
  logic up_valid = 0, up_ready, up_write = 0, up_io = 0;
  logic [AW-1:0] up_addr = 0; logic [BW-1:0] up_be = 0;
  logic dn_valid, dn_ready = 1, dn_write, dn_io, dn_ur;
  logic [AW-1:0] dn_addr; logic [BW-1:0] dn_be;
  logic cpl_in_valid = 0; logic [CW-1:0] cpl_in_data = 0;
  logic cpl_out_valid; logic [CW-1:0] cpl_out_data;
  logic mem_win_en, pref_win_en, io_win_en;
  logic err_primary = 0, perr_detect = 0, perr_clr = 0, serr_msg, perr_status;

  int checks = 0, errors = 0, serr_cnt = 0;
  logic bme_model = 0;
  req_t expq[$];

  always #10 clk = ~clk;

  bridge_cmd_gate #(.ADDR_W(AW), .BE_W(BW), .CPL_W(CW)) u0 (.*);

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (serr_msg) serr_cnt++;
    if (rst_n && dn_valid && dn_ready) begin
      if (expq.size() == 0) chk(0, "R10 unexpected request", 1, 0);
      else begin
        req_t e, a;
        e = expq.pop_front();
        a = '{wr: dn_write, io: dn_io, addr: dn_addr, be: dn_be, ur: dn_ur};
        chk(a == e, bme_model ? "R3 passthrough" : (e.wr ? "R4 write redirect" : "R5 read redirect"),
            64'(a), 64'(e));
      end
    end
  end

  task automatic wr_cmd(input logic [15:0] d);
    @(posedge clk); #1 cfg_wr_en = 1; cfg_wr_data = d;
    @(posedge clk); #1 cfg_wr_en = 0;
    bme_model = d[2];
  endtask

  task automatic send(input logic w, input logic io, input logic [AW-1:0] a, input logic [BW-1:0] b);
    req_t e;
    e.wr = w; e.io = bme_model ? io : 1'b0; e.addr = bme_model ? a : RDIR;
    e.be = (bme_model || !w) ? b : '0; e.ur = !bme_model && !w;
    @(posedge clk); #1 up_valid = 1; up_write = w; up_io = io; up_addr = a; up_be = b;
    expq.push_back(e);
    @(posedge clk); #1 up_valid = 0;
  endtask

  initial begin
    #(20 * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int c0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(cfg_rd_data == 16'h0, "R1 reset register", cfg_rd_data, 0);
    chk({mem_win_en, pref_win_en, io_win_en, perr_status, serr_msg} == 5'b0, "R1 reset outputs",
        {mem_win_en, pref_win_en, io_win_en, perr_status, serr_msg}, 0);

    wr_cmd(16'hFFFF); @(negedge clk);
    chk(cfg_rd_data == 16'h0147, "R2 readback mask", cfg_rd_data, 16'h0147);
    chk({mem_win_en, pref_win_en, io_win_en} == 3'b111, "R7 windows on", {mem_win_en, pref_win_en, io_win_en}, 3'b111);
    wr_cmd(16'h0001); @(negedge clk);
    chk({mem_win_en, pref_win_en, io_win_en} == 3'b001, "R7 io only", {mem_win_en, pref_win_en, io_win_en}, 3'b001);
    wr_cmd(16'hFEB8); @(negedge clk);
    chk(cfg_rd_data == 16'h0000, "R2 reserved bits ignored", cfg_rd_data, 0);
    wr_cmd(16'h0002); @(negedge clk);
    chk({mem_win_en, pref_win_en, io_win_en} == 3'b110, "R7 memory pair", {mem_win_en, pref_win_en, io_win_en}, 3'b110);

    // Bus mastering enabled
    wr_cmd(16'h0004);
    send(1, 0, 40'hAB_1234_5678, 8'hF0);
    send(0, 1, 40'h00_0000_0CF8, 8'h0F);
    send(1, 1, 40'h12_0000_0080, 8'h03);
    send(0, 0, 40'hFF_FFFF_FFFC, 8'hFF);
    // Bus mastering disabled: redirects
    wr_cmd(16'h0000);
    send(1, 0, 40'hAB_1234_5678, 8'hFF);  // memory write / MSI
    send(1, 1, 40'h00_0000_03F8, 8'h01);  // I/O write
    send(0, 0, 40'hFF_FFFF_FFF0, 8'h5A);  // memory read
    send(0, 1, 40'h00_0000_0060, 8'h80);  // I/O read

    // R10 back-pressure holds both sides
    @(posedge clk); #1 dn_ready = 0; up_valid = 1; up_write = 1; up_addr = 40'h1; up_be = 8'h1;
    @(negedge clk);
    chk(!up_ready && dn_valid, "R10 back-pressure", {up_ready, dn_valid}, 2'b01);
    expq.push_back('{wr: 1'b1, io: 1'b0, addr: RDIR, be: '0, ur: 1'b0});
    @(posedge clk); #1 dn_ready = 1;
    @(posedge clk); #1 up_valid = 0;
    @(negedge clk);
    chk(expq.size() == 0, "R10 all requests seen", expq.size(), 0);

    // R6 completions under both gate states
    #1 cpl_in_valid = 1; cpl_in_data = 24'hC0FFEE; #1;
    chk(cpl_out_valid && cpl_out_data == 24'hC0FFEE, "R6 completion gate closed", cpl_out_data, 24'hC0FFEE);
    wr_cmd(16'h0004);
    #1 cpl_in_data = 24'h123456; #1;
    chk(cpl_out_valid && cpl_out_data == 24'h123456, "R6 completion gate open", cpl_out_data, 24'h123456);
    cpl_in_valid = 0;

    // R8 parity status
    @(posedge clk); #1 perr_detect = 1; @(posedge clk); #1 perr_detect = 0;
    @(negedge clk);
    chk(perr_status == 0, "R8 blocked without enable", perr_status, 0);
    wr_cmd(16'h0040);
    @(posedge clk); #1 perr_detect = 1; @(posedge clk); #1 perr_detect = 0;
    @(negedge clk);
    chk(perr_status == 1, "R8 set with enable", perr_status, 1);
    @(posedge clk); #1 perr_clr = 1; @(posedge clk); #1 perr_clr = 0;
    @(negedge clk);
    chk(perr_status == 0, "R8 write-1-to-clear", perr_status, 0);
    @(posedge clk); #1 perr_clr = 1; perr_detect = 1; @(posedge clk); #1 perr_clr = 0; perr_detect = 0;
    @(negedge clk);
    chk(perr_status == 1, "R8 set beats clear", perr_status, 1);

    // R9 message strobes
    c0 = serr_cnt;
    @(posedge clk); #1 err_primary = 1; @(posedge clk); #1 err_primary = 0;
    repeat (3) @(negedge clk);
    chk(serr_cnt == c0, "R9 no strobe when disabled", serr_cnt - c0, 0);
    wr_cmd(16'h0100);
    c0 = serr_cnt;
    @(posedge clk); #1 err_primary = 1; repeat (2) @(posedge clk); #1 err_primary = 0;
    repeat (3) @(negedge clk);
    chk(serr_cnt - c0 == 2, "R9 one strobe per event", serr_cnt - c0, 2);
    wr_cmd(16'h0000); dev_err_report_en = 1;
    c0 = serr_cnt;
    @(posedge clk); #1 err_primary = 1; @(posedge clk); #1 err_primary = 0;
    @(negedge clk);
    chk(serr_msg == 1, "R9 strobe timing via device control", serr_msg, 1);
    @(negedge clk);
    chk(serr_msg == 0 && serr_cnt - c0 == 1, "R9 strobe lasts one cycle", serr_cnt - c0, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule